// File: doc/BRIEF.md
# Load-Store Byte-Lane Unit

This block carries out byte, halfword and word loads and stores for a 32-bit processor pipeline. It talks to a word-wide memory bus with a waitrequest handshake. A single `start` pulse delivers an operation code, a base register value, a 16-bit signed displacement, the value to store and a destination register index. The unit adds the base and the sign-extended displacement to form the effective address. It then issues one word-aligned read or write. The byte enables on that access follow the access size and the low address bits.

For stores, the unit copies the narrow value into every lane of the write data, so the enabled lanes always hold the right bytes. For loads, it captures the whole word, selects the addressed byte or halfword inside the block, and then sign- or zero-extends it. When the access ends, `done` pulses for one cycle. A load that names a non-zero destination register asserts `rd_we` in that same cycle, with `rd_data` and `rd_idx` valid.

The operation code is `{store, unsigned, size[1:0]}`. Size 0 is a byte, 1 is a halfword and 2 is a word. This gives eight operations:

| Code | Operation |
|------|-----------|
| 4'b0000 | signed byte load |
| 4'b0001 | signed halfword load |
| 4'b0010 | word load |
| 4'b0100 | unsigned byte load |
| 4'b0101 | unsigned halfword load |
| 4'b1000 | byte store |
| 4'b1001 | halfword store |
| 4'b1010 | word store |

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is the full 32-bit sum of `base` and the sign-extended 16-bit `offset`, so negative displacements and displacements above 3 both work. `bus_addr` carries that sum with bits [1:0] forced to zero.
- R2: Lanes are little-endian, and `bus_byteen` bit i enables bits [8i+7:8i]. Byte accesses enable only lane `ea[1:0]`. Halfword accesses enable 4'b0011 when `ea[1]`=0 and 4'b1100 when `ea[1]`=1. Word accesses enable 4'b1111. Reads and writes use the same rule.
- R3: Stores put the byte in all four lanes and the halfword in both halves; word stores send the value unchanged. After a byte or halfword store, the other bytes of the memory word are unchanged.
- R4: Code 4'b0000 returns the addressed byte and code 4'b0001 returns the addressed halfword, each sign-extended to 32 bits.
- R5: Code 4'b0100 returns the addressed byte and code 4'b0101 returns the addressed halfword, each zero-extended. Code 4'b0010 returns the whole word.
- R6: While `bus_waitreq` is high during a request, the unit holds the request and keeps its address, enables and data stable. A read and a write are never asserted together.
- R7: `done` is high for exactly one cycle, the cycle after the one in which the bus accepted the request. For a load, `rd_we`, `rd_idx` and `rd_data` are valid in that cycle.
- R8: `rd_we` stays low for every store and for any load whose destination index is 0.
- R9: A `start` that arrives while `busy` is high is ignored. The current access keeps its address, and no extra access follows it.
- R10: After reset, `busy`, `bus_read`, `bus_write`, `done` and `rd_we` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 4 | Operation code {store, unsigned, size} |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_val | input | 32 | Register value to store |
| dest | input | 5 | Destination register index for loads |
| busy | output | 1 | Operation in progress |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_read | output | 1 | Read request |
| bus_write | output | 1 | Write request |
| bus_byteen | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Write data with lanes replicated |
| bus_rdata | input | 32 | Read data word |
| bus_waitreq | input | 1 | Slave stall; the request must be held while it is high |
| done | output | 1 | One-cycle completion pulse |
| rd_we | output | 1 | Register write enable for loads |
| rd_idx | output | 5 | Register index to write |
| rd_data | output | 32 | Extended load result |

## Verification
The assertions check the bus handshake on every cycle:
- the request and its payload stay frozen while the slave stalls;
- reads and writes are exclusive;
- the address stays word-aligned, and a write carries one, two or four enables;
- `done` is a single pulse that follows an accepted transfer;
- no register write targets index 0.

Only the bench's scenarios can show that the values are right. A shadow byte memory checks the effective address, the exact enable pattern, the extension of the loaded lanes and the preservation of neighbouring bytes after narrow stores. The bench drives random stalls, negative and large displacements, and a second `start` during a held request.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DONE} lsu_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // enable pattern for an access of size sz at byte offset lo
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << lo;
      SZ_HALF: lane_mask = lo[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // copy a narrow store value into every lane it may occupy
  function automatic logic [DATA_W-1:0] replicate(input logic [1:0] sz, input logic [DATA_W-1:0] v);
    case (sz)
      SZ_BYTE: replicate = {LANES{v[7:0]}};
      SZ_HALF: replicate = {2{v[15:0]}};
      default: replicate = v;
    endcase
  endfunction

  // widen a selected byte or halfword to the full data width
  function automatic logic [DATA_W-1:0] widen(input logic [1:0] sz, input logic uns,
                                              input logic [15:0] raw, input logic [DATA_W-1:0] word);
    case (sz)
      SZ_BYTE: widen = {{(DATA_W-8){raw[7] & ~uns}}, raw[7:0]};
      SZ_HALF: widen = {{(DATA_W-16){raw[15] & ~uns}}, raw};
      default: widen = word;
    endcase
  endfunction
endpackage

// File: rtl/lsu_agu.sv
`timescale 1ns/1ps
module lsu_agu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  offset,
  input  logic [1:0]        sz,
  input  logic [DATA_W-1:0] store_val,
  output logic [ADDR_W-1:0] ea,
  output logic [LANES-1:0]  mask,
  output logic [DATA_W-1:0] wdata
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] disp;
  assign disp  = {{EXT_W{offset[IMM_W-1]}}, offset};
  assign ea    = base + disp;
  assign mask  = lane_mask(sz, ea[1:0]);
  assign wdata = replicate(sz, store_val);
endmodule

// File: rtl/lsu_fsm.sv
`timescale 1ns/1ps
module lsu_fsm
  import lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_store,
  input  logic       waitreq,
  output lsu_state_e state,
  output logic       take,
  output logic       accept,
  output logic       req_rd,
  output logic       req_wr,
  output logic       done_p
);
  lsu_state_e nxt;

  assign take   = (state == ST_IDLE) && start;
  assign accept = (state == ST_REQ) && !waitreq;
  assign req_rd = (state == ST_REQ) && !is_store;
  assign req_wr = (state == ST_REQ) && is_store;
  assign done_p = (state == ST_DONE);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (take)   nxt = ST_REQ;
      ST_REQ:  if (accept) nxt = ST_DONE;
      default:             nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
endmodule

// File: rtl/lsu_load_align.sv
`timescale 1ns/1ps
module lsu_load_align
  import lsu_pkg::*;
(
  input  logic [1:0]        sz,
  input  logic              uns,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] value
);
  logic [7:0]  lane [LANES];
  logic [15:0] raw;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[8*g +: 8];
  end

  always_comb begin
    if (sz == SZ_BYTE) raw = {8'h00, lane[lo]};
    else               raw = lo[1] ? {lane[3], lane[2]} : {lane[1], lane[0]};
  end

  assign value = widen(sz, uns, raw, word);
endmodule

// File: rtl/lsu_lane_unit.sv
`timescale 1ns/1ps
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  offset,
  input  logic [31:0]       store_val,
  input  logic [RIDX_W-1:0] dest,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic              bus_write,
  output logic [3:0]        bus_byteen,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_waitreq,
  output logic              done,
  output logic              rd_we,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [31:0]       rd_data
);
  lsu_state_e        state;
  logic              take, accept, req_rd, req_wr, done_p;
  logic [ADDR_W-1:0] agu_ea;
  logic [LANES-1:0]  agu_mask;
  logic [DATA_W-1:0] agu_wdata;

  logic [3:0]        op_q;
  logic [ADDR_W-1:0] ea_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] wdata_q, word_q;
  logic [RIDX_W-1:0] dest_q;

  lsu_agu #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agu (
    .base(base), .offset(offset), .sz(op[1:0]), .store_val(store_val),
    .ea(agu_ea), .mask(agu_mask), .wdata(agu_wdata)
  );

  lsu_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(op_q[3]),
    .waitreq(bus_waitreq), .state(state), .take(take), .accept(accept),
    .req_rd(req_rd), .req_wr(req_wr), .done_p(done_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      ea_q    <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
      dest_q  <= '0;
      word_q  <= '0;
    end else begin
      if (take) begin
        op_q    <= op;
        ea_q    <= agu_ea;
        mask_q  <= agu_mask;
        wdata_q <= agu_wdata;
        dest_q  <= dest;
      end
      if (accept && !op_q[3]) word_q <= bus_rdata;
    end
  end

  lsu_load_align u_align (
    .sz(op_q[1:0]), .uns(op_q[2]), .lo(ea_q[1:0]), .word(word_q), .value(rd_data)
  );

  assign busy       = (state != ST_IDLE);
  assign bus_addr   = {ea_q[ADDR_W-1:2], 2'b00};
  assign bus_byteen = mask_q;
  assign bus_wdata  = wdata_q;
  assign bus_read   = req_rd;
  assign bus_write  = req_wr;
  assign done       = done_p;
  assign rd_we      = done_p && !op_q[3] && (dest_q != '0);
  assign rd_idx     = dest_q;
endmodule

// File: rtl/lsu_lane_unit_chk.sv
`timescale 1ns/1ps
module lsu_lane_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_read,
  input logic              bus_write,
  input logic [3:0]        bus_byteen,
  input logic [31:0]       bus_wdata,
  input logic              bus_waitreq,
  input logic              done,
  input logic              rd_we,
  input logic [RIDX_W-1:0] rd_idx
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read || bus_write) && bus_waitreq |=>
      $stable(bus_read) && $stable(bus_write) && $stable(bus_addr) &&
      $stable(bus_byteen) && $stable(bus_wdata));

  assert_rw_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read && bus_write));

  assert_addr_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read || bus_write) |-> bus_addr[1:0] == 2'b00);

  assert_wr_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> ($countones(bus_byteen) == 1 || bus_byteen == 4'b0011 ||
                   bus_byteen == 4'b1100 || bus_byteen == 4'b1111));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && $past((bus_read || bus_write) && !bus_waitreq));

  assert_no_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> done && rd_idx != '0);
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_addr(bus_addr),
  .bus_read(bus_read), .bus_write(bus_write), .bus_byteen(bus_byteen),
  .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq), .done(done),
  .rd_we(rd_we), .rd_idx(rd_idx)
);

// File: tb/sim_lsu_lane_unit.sv
`timescale 1ns/1ps
module sim_lsu_lane_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, busy, bus_read, bus_write, bus_waitreq, done, rd_we;
  logic [3:0]  op, bus_byteen;
  logic [31:0] base, store_val, bus_addr, bus_wdata, bus_rdata, rd_data;
  logic [15:0] offset;
  logic [4:0]  dest, rd_idx;

  int checks = 0, errors = 0;
  logic [7:0]  shadow [64];
  logic [31:0] mem [16];
  bit force_stall = 0, rand_stall = 0;

  lsu_lane_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base(base), .offset(offset),
    .store_val(store_val), .dest(dest), .busy(busy), .bus_addr(bus_addr),
    .bus_read(bus_read), .bus_write(bus_write), .bus_byteen(bus_byteen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq),
    .done(done), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // memory slave: word array, byte-enabled writes, random stalls
  assign bus_rdata = mem[bus_addr[5:2]];
  always @(posedge clk) begin
    if (bus_write && !bus_waitreq)
      for (int i = 0; i < 4; i++)
        if (bus_byteen[i]) mem[bus_addr[5:2]][8*i +: 8] <= bus_wdata[8*i +: 8];
    bus_waitreq <= force_stall ? 1'b1 : (rand_stall ? ($urandom % 3 == 0) : 1'b0);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input logic [1:0] sz, input logic [31:0] ea);
    if (sz == 2'd0) return 4'b1 << ea[1:0];
    if (sz == 2'd1) return (ea[1] == 1'b0) ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_load(input logic [3:0] o, input logic [31:0] ea);
    int a;
    logic [15:0] h;
    if (o[1:0] == 2'd0) begin
      a = int'(ea[5:0]);
      return o[2] ? {24'h0, shadow[a]} : {{24{shadow[a][7]}}, shadow[a]};
    end
    if (o[1:0] == 2'd1) begin
      a = int'(ea[5:0]) & ~1;
      h = {shadow[a+1], shadow[a]};
      return o[2] ? {16'h0, h} : {{16{h[15]}}, h};
    end
    a = int'(ea[5:0]) & ~3;
    return {shadow[a+3], shadow[a+2], shadow[a+1], shadow[a]};
  endfunction

  function automatic void apply_store(input logic [3:0] o, input logic [31:0] ea, input logic [31:0] v);
    int a = int'(ea[5:0]);
    if (o[1:0] == 2'd0) shadow[a] = v[7:0];
    else if (o[1:0] == 2'd1) begin
      a = a & ~1; shadow[a] = v[7:0]; shadow[a+1] = v[15:8];
    end else begin
      a = a & ~3;
      for (int i = 0; i < 4; i++) shadow[a+i] = v[8*i +: 8];
    end
  endfunction

  task automatic access(input logic [3:0] o, input logic [31:0] ea, input logic [15:0] off,
                        input logic [31:0] sv, input logic [4:0] d);
    bit seen = 0, prev_acc = 0, got = 0;
    int a;
    @(negedge clk);
    op = o; offset = off; base = ea - {{16{off[15]}}, off}; store_val = sv; dest = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 100; n++) begin
      if (done) begin got = 1; break; end
      if (prev_acc) chk(0, "R7 done late", {31'd0, done}, 32'd1);
      if ((bus_read || bus_write) && !seen) begin
        seen = 1;
        chk(bus_addr == {ea[31:2], 2'b00}, "R1 addr", bus_addr, {ea[31:2], 2'b00});
        chk(bus_byteen == exp_mask(o[1:0], ea), "R2 byteen", {28'd0, bus_byteen}, {28'd0, exp_mask(o[1:0], ea)});
        chk(bus_write == o[3] && bus_read == !o[3], "R6 direction", {30'd0, bus_read, bus_write}, {30'd0, !o[3], o[3]});
      end
      prev_acc = (bus_read || bus_write) && !bus_waitreq;
      @(negedge clk);
    end
    chk(got && prev_acc, "R7 done after accept", {31'd0, got}, 32'd1);
    if (o[3]) begin
      chk(!rd_we, "R8 store no write", {31'd0, rd_we}, 32'd0);
      apply_store(o, ea, sv);
      a = int'(ea[5:0]) & ~3;
      chk(mem[ea[5:2]] == {shadow[a+3], shadow[a+2], shadow[a+1], shadow[a]}, "R3 memory word",
          mem[ea[5:2]], {shadow[a+3], shadow[a+2], shadow[a+1], shadow[a]});
    end else begin
      chk(rd_we == (d != 0), "R8 load write enable", {31'd0, rd_we}, {31'd0, d != 0});
      chk(rd_idx == d, "R7 rd_idx", {27'd0, rd_idx}, {27'd0, d});
      chk(rd_data == exp_load(o, ea), o[2] || o[1] ? "R5 load value" : "R4 load value",
          rd_data, exp_load(o, ea));
    end
    @(negedge clk);
    chk(!done && !busy, "R7 single pulse", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] ops [8];
    logic [31:0] w, ea;
    logic [3:0] o;
    bit extra;
    ops = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA};
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) begin
      w = $urandom; mem[i] = w;
      for (int b = 0; b < 4; b++) shadow[4*i+b] = w[8*b +: 8];
    end
    rst_n = 0; start = 0; op = 0; base = 0; offset = 0; store_val = 0; dest = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_read && !bus_write && !done && !rd_we, "R10 in reset",
        {27'd0, busy, bus_read, bus_write, done, rd_we}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_read && !bus_write && !done && !rd_we, "R10 after reset",
        {27'd0, busy, bus_read, bus_write, done, rd_we}, 32'd0);

    // directed: sign vs zero extension, negative and large offsets
    access(4'h8, 32'd5,  16'hFFFC, 32'h1234_5680, 5'd0);   // R3 byte store, negative offset
    access(4'h0, 32'd5,  16'h0007, 32'h0, 5'd3);            // R4 0xFFFFFF80
    access(4'h4, 32'd5,  16'h8000, 32'h0, 5'd4);            // R5 0x00000080
    access(4'h9, 32'd10, 16'h7FFC, 32'hABCD_8001, 5'd0);    // R3 halfword store, upper half
    access(4'h1, 32'd10, 16'hFFFF, 32'h0, 5'd5);            // R4 0xFFFF8001
    access(4'h5, 32'd10, 16'h0040, 32'h0, 5'd6);            // R5 0x00008001
    access(4'hA, 32'd20, 16'h0010, 32'hDEAD_BEEF, 5'd1);    // R3 word store
    access(4'h2, 32'd20, 16'hFFF0, 32'h0, 5'd0);            // R8 dest 0 suppresses

    // R9: second start during a held request is ignored
    force_stall = 1;
    @(negedge clk);
    op = 4'h2; offset = 16'd0; base = 32'd32; dest = 5'd9; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    op = 4'hA; base = 32'd48; start = 1;
    @(negedge clk);
    start = 0;
    chk(bus_read && bus_addr == 32'd32, "R9 addr held", bus_addr, 32'd32);
    force_stall = 0;
    while (!done) @(negedge clk);
    chk(rd_data == exp_load(4'h2, 32'd32), "R9 first op result", rd_data, exp_load(4'h2, 32'd32));
    extra = 0;
    repeat (4) begin
      @(negedge clk);
      if (busy || bus_read || bus_write) extra = 1;
    end
    chk(!extra, "R9 no extra access", {31'd0, extra}, 32'd0);

    // random mix with stalls
    rand_stall = 1;
    for (int k = 0; k < 400; k++) begin
      o = ops[$urandom % 8];
      ea = {26'd0, 6'($urandom)};
      if (o[1:0] == 2'd1) ea[0] = 1'b0;
      if (o[1:0] == 2'd2) ea[1:0] = 2'b00;
      access(o, ea, 16'($urandom), $urandom, 5'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule